// File: doc/BRIEF.md
# Debug and Lifecycle Security State Controller

This block turns a three-bit security state word into an operating mode and decides when that mode may change. The most significant bit is the debug-lock flag. The two low bits are the lifecycle stage. The block opens the debug (JTAG) port only when the mode allows it. Before it grants any live unlock, it requests zeroization of every security-critical key. It also holds the processor core in reset while the part is retired or has not yet completed its first cold boot.

The state word is adopted as-is only when the cold-boot strobe is high. Between cold boots, exactly one live change is accepted: from a locked manufacturing or locked production mode to unlocked production. That change first passes through a zeroize phase, which ends with a done handshake from the key storage. Every other live change is held off until the next cold boot. This includes relocking, leaving the unprovisioned mode, manufacturing to production, and any move into or out of retirement.

For each key, a per-key override code tells the key storage what value to present while the part is insecure. The code is fixed by a parameter for each key.

Top module: `secst_ctrl`

## Requirements
- R1: While reset is low, and after reset until the first cold boot, `jtag_en`, `zero_req`, `dbg_key_sel` and `key_sel` are 0 and `core_hold` is 1.
- R2: In a cycle with `cold_boot` high, `sec_state` is adopted from the next cycle. The codes are: 000 is unlocked unprovisioned, 001 is unlocked production, 100 is locked manufacturing and 101 is locked production. `jtag_en` is 1 exactly in the two unlocked modes, and `core_hold` is 0 in all four.
- R3: Codes 010 and 110 are reserved and act as a locked secure mode. `jtag_en` is 0, there is no key override and no hold, and no live input leaves this mode.
- R4: Any code whose low two bits are 11 is the retired mode when adopted at cold boot. `core_hold` is 1 and `jtag_en` is 0 until the next cold boot, whatever the live input.
- R5: In locked manufacturing or locked production, a live input of 001 raises `zero_req` one cycle later, with `jtag_en` still 0.
- R6: `zero_req` stays high until a cycle with `zero_done` high. From the next cycle `zero_req` is 0 and `jtag_en` is 1. The two are never high together.
- R7: In an unlocked mode, a live input that names any other state leaves the mode and `jtag_en` unchanged.
- R8: Live inputs other than 001 in the locked modes leave the mode unchanged. This covers the move to production, the move to unprovisioned and the retired codes.
- R9: `zero_done` has no effect outside the zeroize phase.
- R10: While the mode is unlocked or zeroizing, `dbg_key_sel` is 1 and each 2-bit field i of `key_sel` equals field i of `KEY_KINDS`. The field codes are 01 for all zeros, 10 for all ones and 11 for the debug key. Otherwise `dbg_key_sel` and `key_sel` are 0. The default `KEY_KINDS` is 8'hE5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cold_boot | input | 1 | High for one cycle at each power-cycle boot |
| sec_state | input | 3 | Lock flag (bit 2) and lifecycle stage (bits 1:0) |
| zero_done | input | 1 | Key storage has finished zeroizing |
| jtag_en | output | 1 | Debug port may be opened |
| zero_req | output | 1 | Request to zeroize all secret keys |
| key_sel | output | 2*NUM_KEYS | Per-key override value code |
| dbg_key_sel | output | 1 | Insecure key values are in force |
| core_hold | output | 1 | Hold the core in reset |

## Verification
The bench boots into each of the eight codes and then applies each of the eight codes as a live input, so that every source and target pair is covered.

The pairs in this sweep are aimed at the following faults:
- A design that lets a relock, a lifecycle advance or an exit from unprovisioned take effect live would show a changed `jtag_en` or a `zero_req` where none is expected.
- A design that opens the port together with the zeroize request, or before the done handshake, is caught by checks made in the same cycle as `zero_done` and in the waits before it.
- Decoding a reserved code as unlocked would open the port.
- Treating retired as reachable live, or as leavable live, would change `core_hold`.

A stray `zero_done` is pulsed in every non-zeroize case.

// File: rtl/secst_pkg.sv
// Shared mode encoding for the security state controller.
// Assumes: modes fit in three bits; OFF is the post-reset, pre-boot mode.
package secst_pkg;
    typedef enum logic [2:0] {
        MODE_OFF       = 3'd0,
        MODE_UNPROV    = 3'd1,
        MODE_MANUF     = 3'd2,
        MODE_PROD_LOCK = 3'd3,
        MODE_PROD_DBG  = 3'd4,
        MODE_RETIRED   = 3'd5,
        MODE_SECURE    = 3'd6,
        MODE_ZEROIZE   = 3'd7
    } mode_t;
endpackage

// File: rtl/secst_decode.sv
// Maps the raw three-bit security word onto a mode.
// Assumes: bit 2 is the lock flag, bits 1:0 the lifecycle stage; anything
// that is not a defined code or retirement falls back to the secure mode.
module secst_decode
    import secst_pkg::*;
(
    input  logic [2:0] state_in,
    output mode_t      mode_out
);
    logic       lock_bit;
    logic [1:0] stage;

    assign lock_bit = state_in[2];
    assign stage    = state_in[1:0];

    // Purpose: pick the mode for the lock flag and lifecycle stage.
    always_comb begin
        if (stage == 2'b11)                 mode_out = MODE_RETIRED;
        else if (!lock_bit && stage == 2'b00) mode_out = MODE_UNPROV;
        else if (!lock_bit && stage == 2'b01) mode_out = MODE_PROD_DBG;
        else if (lock_bit && stage == 2'b00)  mode_out = MODE_MANUF;
        else if (lock_bit && stage == 2'b01)  mode_out = MODE_PROD_LOCK;
        else                                  mode_out = MODE_SECURE;
    end
endmodule

// File: rtl/secst_fsm.sv
// Holds the active mode and applies the transition rules.
// Assumes: cold_boot marks a power cycle; only locked->unlocked-production
// is accepted live and it always passes through the zeroize phase.
module secst_fsm
    import secst_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cold_boot,
    input  mode_t req_mode,
    input  logic  zero_done,
    output mode_t cur_mode
);
    mode_t next_mode;

    // Purpose: decide the next mode from the current one and the request.
    always_comb begin
        next_mode = cur_mode;
        if (cold_boot) begin
            next_mode = req_mode;
        end else begin
            case (cur_mode)
                MODE_MANUF, MODE_PROD_LOCK:
                    if (req_mode == MODE_PROD_DBG) next_mode = MODE_ZEROIZE;
                MODE_ZEROIZE:
                    if (zero_done) next_mode = MODE_PROD_DBG;
                default: next_mode = cur_mode;
            endcase
        end
    end

    // Purpose: mode register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_mode <= MODE_OFF;
        else        cur_mode <= next_mode;
    end
endmodule

// File: rtl/secst_keymux.sv
// Drives one override code per key while the part is insecure.
// Assumes: KINDS holds a 2-bit code per key (01 zeros, 10 ones, 11 debug).
module secst_keymux #(
    parameter int                      NUM_KEYS = 4,
    parameter logic [2*NUM_KEYS-1:0]   KINDS    = 8'hE5
) (
    input  logic                  insecure,
    output logic [2*NUM_KEYS-1:0] sel_out
);
    // Purpose: one gated field per key.
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        assign sel_out[2*k +: 2] = insecure ? KINDS[2*k +: 2] : 2'b00;
    end
endmodule

// File: rtl/secst_ctrl.sv
// Security state controller top: decode, mode register, key overrides.
// Assumes: key storage answers zero_req with zero_done; the debug port and
// core reset logic consume jtag_en and core_hold directly.
module secst_ctrl
    import secst_pkg::*;
#(
    parameter int                    NUM_KEYS  = 4,
    parameter logic [2*NUM_KEYS-1:0] KEY_KINDS = 8'hE5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cold_boot,
    input  logic [2:0]            sec_state,
    input  logic                  zero_done,
    output logic                  jtag_en,
    output logic                  zero_req,
    output logic [2*NUM_KEYS-1:0] key_sel,
    output logic                  dbg_key_sel,
    output logic                  core_hold
);
    mode_t req_mode;
    mode_t cur_mode;
    logic  insecure;

    secst_decode u_dec (
        .state_in (sec_state),
        .mode_out (req_mode)
    );

    secst_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cold_boot (cold_boot),
        .req_mode  (req_mode),
        .zero_done (zero_done),
        .cur_mode  (cur_mode)
    );

    // Purpose: Moore outputs from the active mode.
    always_comb begin
        jtag_en   = (cur_mode == MODE_UNPROV) || (cur_mode == MODE_PROD_DBG);
        zero_req  = (cur_mode == MODE_ZEROIZE);
        insecure  = jtag_en || zero_req;
        core_hold = (cur_mode == MODE_OFF) || (cur_mode == MODE_RETIRED);
    end

    assign dbg_key_sel = insecure;

    secst_keymux #(
        .NUM_KEYS (NUM_KEYS),
        .KINDS    (KEY_KINDS)
    ) u_keys (
        .insecure (insecure),
        .sel_out  (key_sel)
    );
endmodule

// File: rtl/secst_ctrl_chk.sv
// Port-level temporal checks for secst_ctrl, attached by bind.
module secst_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cold_boot,
    input logic [2:0] sec_state,
    input logic       zero_done,
    input logic       jtag_en,
    input logic       zero_req,
    input logic       dbg_key_sel,
    input logic       core_hold
);
    AST_NO_JTAG_WITH_ZREQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(jtag_en && zero_req)); // R6
    AST_JTAG_OPEN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jtag_en) |-> ($past(cold_boot) || $past(zero_req && zero_done))); // R6
    AST_ZREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_req && !zero_done && !cold_boot) |=> zero_req); // R6
    AST_ZREQ_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_req) |-> ($past(!cold_boot) && $past(sec_state) == 3'b001)); // R5
    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold && !cold_boot) |=> core_hold); // R4
    AST_NO_LIVE_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (jtag_en && !cold_boot) |=> jtag_en); // R7
    AST_KEYS_WITH_JTAG: assert property (@(posedge clk) disable iff (!rst_n)
        jtag_en |-> dbg_key_sel); // R10
endmodule

bind secst_ctrl secst_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cold_boot   (cold_boot),
    .sec_state   (sec_state),
    .zero_done   (zero_done),
    .jtag_en     (jtag_en),
    .zero_req    (zero_req),
    .dbg_key_sel (dbg_key_sel),
    .core_hold   (core_hold)
);

// File: tb/tb_secst_ctrl.sv
// Sweeps every boot code against every live code and checks the outputs.
module tb_secst_ctrl;
    localparam int         NK    = 4;
    localparam logic [7:0] KINDS = 8'hE5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cold_boot = 1'b0;
    logic [2:0]   sec_state = 3'b000;
    logic         zero_done = 1'b0;
    logic         jtag_en, zero_req, dbg_key_sel, core_hold;
    logic [2*NK-1:0] key_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    secst_ctrl #(.NUM_KEYS(NK), .KEY_KINDS(KINDS)) dut (
        .clk(clk), .rst_n(rst_n), .cold_boot(cold_boot), .sec_state(sec_state),
        .zero_done(zero_done), .jtag_en(jtag_en), .zero_req(zero_req),
        .key_sel(key_sel), .dbg_key_sel(dbg_key_sel), .core_hold(core_hold)
    );

    // Packed observation: {jtag, zreq, hold, dbgsel, keys}
    function automatic logic [11:0] expect_vec(input bit jt, input bit zr, input bit hd);
        bit ins;
        ins = jt | zr;
        return {jt, zr, hd, ins, (ins ? KINDS : 8'h00)};
    endfunction

    task automatic check(input string req, input logic [11:0] exp);
        logic [11:0] act;
        act = {jtag_en, zero_req, core_hold, dbg_key_sel, key_sel};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %03h expected %03h", req, act, exp);
        end
    endtask

    task automatic boot(input logic [2:0] s);
        @(negedge clk); sec_state = s; cold_boot = 1'b1;
        @(negedge clk); cold_boot = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", expect_vec(0, 0, 1));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        zero_done = 1'b1; @(negedge clk); zero_done = 1'b0;
        check("R1", expect_vec(0, 0, 1));

        for (int b = 0; b < 8; b++) begin
            for (int t = 0; t < 8; t++) begin
                logic [2:0] bs, ts;
                bit unl, ret, lck, zz;
                bs = 3'(b); ts = 3'(t);
                boot(bs);
                ret = (bs[1:0] == 2'b11);
                unl = !ret && !bs[2] && !bs[1];
                lck = !ret && bs[2] && !bs[1];
                if (unl) check("R2", expect_vec(1, 0, 0));
                else if (ret) check("R4", expect_vec(0, 0, 1));
                else if (lck) check("R2", expect_vec(0, 0, 0));
                else check("R3", expect_vec(0, 0, 0));

                @(negedge clk); sec_state = ts;
                repeat (2) @(negedge clk);
                zz = lck && (ts == 3'b001);
                if (zz) begin
                    check("R5", expect_vec(0, 1, 0));
                    repeat (3) @(negedge clk);
                    check("R6", expect_vec(0, 1, 0));
                    zero_done = 1'b1; #1;
                    check("R6", expect_vec(0, 1, 0));
                    @(negedge clk); zero_done = 1'b0;
                    check("R10", expect_vec(1, 0, 0));
                    @(negedge clk);
                    check("R6", expect_vec(1, 0, 0));
                end else begin
                    if (unl) check("R7", expect_vec(1, 0, 0));
                    else if (ret) check("R4", expect_vec(0, 0, 1));
                    else if (lck) check("R8", expect_vec(0, 0, 0));
                    else check("R3", expect_vec(0, 0, 0));
                    zero_done = 1'b1; @(negedge clk); zero_done = 1'b0;
                    @(negedge clk);
                    check("R9", expect_vec(unl, 0, ret));
                end
            end
        end

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1", expect_vec(0, 0, 1));
        rst_n = 1'b1;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule